// File: doc/BRIEF.md
# Two-Digit Decimal Adder-Subtractor with Sign-Magnitude Result

This block adds or subtracts two unsigned packed-BCD numbers of two decimal digits each. A single mode input picks the operation. In both modes the work is done by one chain of per-digit binary adders with decimal correction. In subtract mode the subtrahend is first replaced by its nine's complement and a carry of one enters the units digit, so the chain produces the ten's complement difference.

A bare ten's-complement chain gives a wrapped answer when the difference is negative: 33 minus 73 comes out as 60. This block corrects that. When a subtraction produces no decimal carry out of the top digit, the raw result is complemented again across every digit, the units digit included. The output then holds the magnitude, and a separate negative flag is raised. In add mode a carry out of the top digit shows a sum of 100 or more.

The block is purely combinational. The digit count is a parameter with a default of two.

Top module: `bcd_addsub`

## Requirements
- R1: With sub_i = 0, res_o is (A + B) mod 100 in packed BCD (units in bits 3:0, tens in bits 7:4) and neg_o is 0.
- R2: With sub_i = 1 and A > B, res_o is A − B in packed BCD and neg_o is 0.
- R3: With sub_i = 1 and A < B, res_o is the magnitude B − A in packed BCD and neg_o is 1 (for example 33 − 73 gives 40 with neg_o set).
- R4: ovf_o is 1 exactly when sub_i = 0 and A + B ≥ 100; with sub_i = 1 ovf_o is always 0.
- R5: With sub_i = 1 and A = B, res_o is 00 and neg_o is 0.
- R6: For valid BCD operands, every 4-bit digit of res_o lies in 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Minuend or first addend, packed BCD, units digit in bits 3:0 |
| b_i | input | 8 | Subtrahend or second addend, packed BCD |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts b_i from a_i |
| res_o | output | 8 | Result magnitude, packed BCD |
| neg_o | output | 1 | Set when the difference is negative |
| ovf_o | output | 1 | Decimal carry out of the top digit in add mode |

## Verification
Every result is due in the same cycle as its operands, because no register lies between the ports. The driver applies operands just after a rising edge and queues the expected result. The monitor compares at the next falling edge, half a period later, when the combinational paths have settled. The bench covers all 100 × 100 operand pairs in both modes, so every wrap, carry and zero-difference case is reached.

// File: rtl/bcd_as_pkg.sv
package bcd_as_pkg;
   localparam int DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] bcd_digit_t;

   function automatic bcd_digit_t nines_of(input bcd_digit_t d);
      return 4'd9 - d;
   endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
   import bcd_as_pkg::*;
(
   input  bcd_digit_t a_i,
   input  bcd_digit_t b_i,
   input  logic       cin_i,
   output bcd_digit_t sum_o,
   output logic       cout_o
);
   logic [DIGIT_W:0] bin_sum;

   assign bin_sum = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
   // a binary total above nine, including a 4-bit carry out, needs the +6 fix
   assign cout_o  = bin_sum > 5'd9;
   assign sum_o   = cout_o ? bin_sum[DIGIT_W-1:0] + 4'd6 : bin_sum[DIGIT_W-1:0];

   always_comb begin
      if (a_i <= 4'd9 && b_i <= 4'd9) begin
         assert_digit_bcd_R6: assert (sum_o <= 4'd9)
            else $error("digit result %0d is not BCD", sum_o);
      end
   end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
   import bcd_as_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   logic [DIGITS:0] carry;

   assign carry[0] = cin_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      bcd_digit_add u_dig (
         .a_i   (a_i[g*DIGIT_W +: DIGIT_W]),
         .b_i   (b_i[g*DIGIT_W +: DIGIT_W]),
         .cin_i (carry[g]),
         .sum_o (sum_o[g*DIGIT_W +: DIGIT_W]),
         .cout_o(carry[g+1])
      );
   end

   assign cout_o = carry[DIGITS];
endmodule

// File: rtl/bcd_cond_nines.sv
module bcd_cond_nines
   import bcd_as_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assign d_o[g*DIGIT_W +: DIGIT_W] =
         en_i ? nines_of(d_i[g*DIGIT_W +: DIGIT_W]) : d_i[g*DIGIT_W +: DIGIT_W];
   end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
   import bcd_as_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         neg_o,
   output logic         ovf_o
);
   logic [W-1:0] b_eff, raw, raw_n9, mag_tc;
   logic         main_cout, post_cout, is_neg;

   initial begin
      assert_param_digits: assert (DIGITS >= 1 && DIGITS <= 8)
         else $error("DIGITS out of range: %0d", DIGITS);
   end

   // subtrahend conditioning: nine's complement in subtract mode
   bcd_cond_nines #(.DIGITS(DIGITS)) u_opnd (
      .en_i(sub_i), .d_i(b_i), .d_o(b_eff)
   );

   // main decimal chain; carry-in 1 turns nine's into ten's complement
   bcd_ripple #(.DIGITS(DIGITS)) u_main (
      .a_i(a_i), .b_i(b_eff), .cin_i(sub_i), .sum_o(raw), .cout_o(main_cout)
   );

   // negative when a subtraction leaves no carry out of the top digit
   assign is_neg = sub_i & ~main_cout;

   // post complementer covers every digit: nine's complement then +1
   bcd_cond_nines #(.DIGITS(DIGITS)) u_post_inv (
      .en_i(1'b1), .d_i(raw), .d_o(raw_n9)
   );

   bcd_ripple #(.DIGITS(DIGITS)) u_post_inc (
      .a_i(raw_n9), .b_i('0), .cin_i(1'b1), .sum_o(mag_tc), .cout_o(post_cout)
   );

   assign res_o = is_neg ? mag_tc : raw;
   assign neg_o = is_neg;
   assign ovf_o = ~sub_i & main_cout;

   always_comb begin
      if (sub_i) begin
         assert_sub_no_ovf_R4: assert (!ovf_o) else $error("overflow in subtract mode");
      end
      if (!sub_i) begin
         assert_add_positive_R1: assert (!neg_o) else $error("negative flag in add mode");
      end
      if (sub_i && a_i == b_i) begin
         assert_zero_positive_R5: assert (!neg_o && res_o == '0)
            else $error("zero difference gave %h neg %b", res_o, neg_o);
      end
      if (is_neg) begin
         // a negative raw result is never zero, so its ten's complement cannot wrap
         assert_post_no_wrap_R3: assert (!post_cout) else $error("post complement wrapped");
      end
   end
endmodule

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   typedef struct {
      logic [7:0] a;
      logic [7:0] b;
      logic       sub;
      logic [7:0] exp_res;
      logic       exp_neg;
      logic       exp_ovf;
      int         req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a_i = '0, b_i = '0;
   logic       sub_i = 1'b0;
   logic [7:0] res_o;
   logic       neg_o, ovf_o;

   int  checks = 0;
   int  errors = 0;
   bit  drive_done = 1'b0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_addsub u_bcd_addsub (
      .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
      .res_o(res_o), .neg_o(neg_o), .ovf_o(ovf_o)
   );

   function automatic logic [7:0] to_bcd(input int v);
      logic [7:0] r;
      r[7:4] = 4'((v / 10) % 10);
      r[3:0] = 4'(v % 10);
      return r;
   endfunction

   function automatic string req_name(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic drive(input int av, input int bv, input logic s);
      item_t it;
      @(posedge clk);
      #1;
      a_i = to_bcd(av); b_i = to_bcd(bv); sub_i = s;
      it.a = a_i; it.b = b_i; it.sub = s;
      if (!s) begin
         it.exp_res = to_bcd((av + bv) % 100);
         it.exp_neg = 1'b0;
         it.exp_ovf = (av + bv) >= 100;
         it.req = 1;                                   // R1
      end else if (av > bv) begin
         it.exp_res = to_bcd(av - bv); it.exp_neg = 1'b0; it.exp_ovf = 1'b0;
         it.req = 2;                                   // R2
      end else if (av < bv) begin
         it.exp_res = to_bcd(bv - av); it.exp_neg = 1'b1; it.exp_ovf = 1'b0;
         it.req = 3;                                   // R3
      end else begin
         it.exp_res = 8'h00; it.exp_neg = 1'b0; it.exp_ovf = 1'b0;
         it.req = 5;                                   // R5
      end
      q.push_back(it);
   endtask

   // monitor: result is combinational, compared half a period after drive
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (res_o !== it.exp_res || neg_o !== it.exp_neg) begin
               errors++;
               $display("FAIL %s a=%h b=%h sub=%b res/neg actual %h/%b expected %h/%b",
                        req_name(it.req), it.a, it.b, it.sub, res_o, neg_o,
                        it.exp_res, it.exp_neg);
            end
            checks++;
            if (ovf_o !== it.exp_ovf) begin
               errors++;
               $display("FAIL R4 a=%h b=%h sub=%b ovf actual %b expected %b",
                        it.a, it.b, it.sub, ovf_o, it.exp_ovf);
            end
            checks++;
            if (res_o[7:4] > 4'd9 || res_o[3:0] > 4'd9) begin
               errors++;
               $display("FAIL R6 digit range actual %h expected digits 0..9", res_o);
            end
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // reset state: zero operands in add mode give a zero result (R1)
      checks++;
      if (res_o !== 8'h00 || neg_o !== 1'b0 || ovf_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset state actual %h/%b/%b expected 00/0/0", res_o, neg_o, ovf_o);
      end
      rst_n = 1'b1;
      // named corner cases
      drive(33, 73, 1'b1);   // R3: magnitude 40, negative
      drive(73, 73, 1'b1);   // R5: zero difference
      drive(99, 99, 1'b0);   // R4: 198 wraps to 98 with overflow
      drive(0, 99, 1'b1);    // R3: largest negative
      drive(99, 0, 1'b1);    // R2
      drive(50, 50, 1'b0);   // R4: exactly 100
      // exhaustive sweep of both modes
      for (int s = 0; s < 2; s++)
         for (int av = 0; av < 100; av++)
            for (int bv = 0; bv < 100; bv++)
               drive(av, bv, logic'(s));
      drive_done = 1'b1;
      while (q.size() > 0) @(posedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule